// File: doc/BRIEF.md
# CPU Bus Address Decoder

This block sits on the 16-bit address bus of a game-console style processor and steers each access to one of four targets. The top five address bits pick a 2 KB bank. The lowest four banks share one 2 KB internal work RAM. The next four banks form a window onto eight graphics-controller registers. Bank 8 is a small I/O region with fixed read values. Every bank above that is cartridge program memory.

The processor drives `addr`, the `rd` and `wr` strobes and `wdata` for one cycle per access. Read data comes back from a register one cycle later, whatever the target. The graphics controller itself is outside the block. It sees a one-cycle select strobe, a write indication and a 3-bit register index, takes write data from the shared `wdata` bus, and returns its read data on `gfx_rd_data`.

A static configuration input, sampled only while reset is held, sets a mode for a 16 KB program image. In that mode the upper 16 KB of the cartridge range is an alias of the lower 16 KB.

The cartridge array is sparse. Its index is address bits 15:14 together with the low `CART_LOW_AW` address bits, so each 16 KB quarter keeps its own storage.

Top module: `cpu_bus_decoder`

## Requirements
- R1: While reset is held and after it is released, `rdata` is 0x00 and `gfx_sel` is low until the first read completes.
- R2: A read (`rd`=1, `wr`=0) updates `rdata` at the next rising clock edge. With no read, `rdata` holds its value. When `rd` and `wr` are both high, the access is a write.
- R3: Addresses 0x0000–0x1FFF use address bits 10:0 to index one 2 KB RAM. A byte written at 0x0123 reads back at 0x0923, 0x1123 and 0x1923.
- R4: An access (`rd` or `wr`) in 0x2000–0x3FFF raises `gfx_sel` in the same cycle. In that cycle `gfx_we` equals `wr` and `gfx_idx` equals address bits 2:0, so 0x3FFD gives index 5. `gfx_sel` is low for every other access and whenever the bus is idle.
- R5: A read in the graphics window returns the `gfx_rd_data` value present in the access cycle, one cycle later.
- R6: A read of 0x4017 returns 0x01. A read of any other address in 0x4000–0x47FF returns 0x00.
- R7: Writes to 0x4000–0x47FF have no effect. Later reads of the I/O region are unchanged, and the RAM is not touched.
- R8: Addresses 0x4800–0xFFFF are read/write memory. With the mirror mode off, 0x8000–0xBFFF and 0xC000–0xFFFF hold separate bytes.
- R9: When `mirror16k_cfg` is high during reset, 0xC000–0xFFFF aliases 0x8000–0xBFFF in both directions. A change of `mirror16k_cfg` after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mirror16k_cfg | input | 1 | 16 KB program image mode, sampled during reset |
| addr | input | 16 | Processor address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data, also used by the graphics controller |
| rdata | output | 8 | Registered read data |
| gfx_sel | output | 1 | Graphics register select, one cycle per access |
| gfx_we | output | 1 | Graphics access is a write |
| gfx_idx | output | 3 | Graphics register index |
| gfx_rd_data | input | 8 | Read data from the graphics controller |

## Verification
The bench writes RAM through one mirror and reads it through the other three. A decoder that used too many offset bits would return stale bytes from those mirrors. It probes the I/O region at 0x4017 and at a neighbouring address, both before and after writes there. A wrong decode would let a write change a read value or corrupt the RAM through the shared low bits. In the graphics window it checks the index at the top of the range. Without mirror mode, the cartridge quarters must stay separate. With mirror mode, they must alias in both directions, and the bench flips the configuration input after reset to catch a design that samples it live. Each target's read returns in the same cycle, so a mux with an unregistered path shows up as early data.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_GFX  = 2'd1,
    TGT_IO   = 2'd2,
    TGT_CART = 2'd3
  } tgt_e;

  // bank = addr[15:11]; banks 0..3 RAM, 4..7 graphics, 8 I/O, rest cartridge
  function automatic tgt_e bank_target(input logic [4:0] bank);
    if (bank < 5'd4)       return TGT_RAM;
    else if (bank < 5'd8)  return TGT_GFX;
    else if (bank == 5'd8) return TGT_IO;
    else                   return TGT_CART;
  endfunction

  function automatic logic [7:0] io_value(input logic [15:0] a,
                                          input logic [15:0] probe_addr,
                                          input logic [7:0]  probe_val);
    return (a == probe_addr) ? probe_val : 8'h00;
  endfunction

endpackage

// File: rtl/cbd_decode.sv
module cbd_decode #(
  parameter int RAM_AW      = 11,
  parameter int CART_LOW_AW = 10,
  parameter logic [15:0] IO_PROBE_ADDR = 16'h4017,
  parameter logic [7:0]  IO_PROBE_VAL  = 8'h01
) (
  input  logic [15:0]              addr,
  input  logic                     mirror,
  output cbd_pkg::tgt_e            tgt,
  output logic [RAM_AW-1:0]        ram_idx,
  output logic [CART_LOW_AW+1:0]   cart_idx,
  output logic [7:0]               io_val
);
  logic [15:0] eff;

  always_comb begin
    eff = addr;
    if (mirror && addr[15]) eff[14] = 1'b0;
  end

  assign tgt      = cbd_pkg::bank_target(addr[15:11]);
  assign ram_idx  = addr[RAM_AW-1:0];
  assign cart_idx = {eff[15:14], eff[CART_LOW_AW-1:0]};
  assign io_val   = cbd_pkg::io_value(addr, IO_PROBE_ADDR, IO_PROBE_VAL);
endmodule

// File: rtl/cbd_byte_mem.sv
module cbd_byte_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder #(
  parameter int RAM_AW      = 11,
  parameter int CART_LOW_AW = 10,
  parameter int GFX_IDX_W   = 3,
  parameter logic [15:0] IO_PROBE_ADDR = 16'h4017,
  parameter logic [7:0]  IO_PROBE_VAL  = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mirror16k_cfg,
  input  logic [15:0]          addr,
  input  logic                 rd,
  input  logic                 wr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 gfx_sel,
  output logic                 gfx_we,
  output logic [GFX_IDX_W-1:0] gfx_idx,
  input  logic [7:0]           gfx_rd_data
);
  import cbd_pkg::*;

  localparam int CART_AW = CART_LOW_AW + 2;

  tgt_e               tgt;
  logic [RAM_AW-1:0]  ram_idx;
  logic [CART_AW-1:0] cart_idx;
  logic [7:0]         io_val, ram_q, cart_q, rd_next, rdata_q;
  logic               mirror_q, is_read, ram_we, cart_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mirror_q <= mirror16k_cfg;
  end

  cbd_decode #(
    .RAM_AW(RAM_AW), .CART_LOW_AW(CART_LOW_AW),
    .IO_PROBE_ADDR(IO_PROBE_ADDR), .IO_PROBE_VAL(IO_PROBE_VAL)
  ) u_dec (
    .addr(addr), .mirror(mirror_q), .tgt(tgt),
    .ram_idx(ram_idx), .cart_idx(cart_idx), .io_val(io_val)
  );

  assign is_read = rd && !wr;
  assign ram_we  = wr && (tgt == TGT_RAM);
  assign cart_we = wr && (tgt == TGT_CART);

  cbd_byte_mem #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .idx(ram_idx), .wdata(wdata), .rdata(ram_q)
  );

  cbd_byte_mem #(.AW(CART_AW), .DW(8)) u_cart (
    .clk(clk), .we(cart_we), .idx(cart_idx), .wdata(wdata), .rdata(cart_q)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM:  rd_next = ram_q;
      TGT_GFX:  rd_next = gfx_rd_data;
      TGT_IO:   rd_next = io_val;
      default:  rd_next = cart_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= 8'h00;
    else if (is_read) rdata_q <= rd_next;
  end

  assign rdata   = rdata_q;
  assign gfx_sel = (rd || wr) && (tgt == TGT_GFX);
  assign gfx_we  = wr;
  assign gfx_idx = addr[GFX_IDX_W-1:0];
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rd,
  input logic        wr,
  input logic [7:0]  rdata,
  input logic        gfx_sel,
  input logic        gfx_we,
  input logic [2:0]  gfx_idx
);
  assert_gfx_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_sel |-> (addr[15:13] == 3'b001) && (rd || wr));

  assert_gfx_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_sel |-> (gfx_idx == addr[2:0]) && (gfx_we == wr));

  assert_gfx_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd || wr) |-> !gfx_sel);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && !wr) |=> $stable(rdata));

  assert_io_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr == 16'h4017) |=> (rdata == 8'h01));

  assert_io_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && addr[15:11] == 5'd8 && addr != 16'h4017) |=> (rdata == 8'h00));
endmodule

bind cpu_bus_decoder cbd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .rdata(rdata),
  .gfx_sel(gfx_sel), .gfx_we(gfx_we), .gfx_idx(gfx_idx)
);

// File: tb/tb_cpu_bus_decoder.sv
module tb_cpu_bus_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mirror16k_cfg = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0, gfx_rd_data = '0;
  logic [7:0]  rdata;
  logic        gfx_sel, gfx_we;
  logic [2:0]  gfx_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cpu_bus_decoder dut (
    .clk(clk), .rst_n(rst_n), .mirror16k_cfg(mirror16k_cfg), .addr(addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .gfx_sel(gfx_sel),
    .gfx_we(gfx_we), .gfx_idx(gfx_idx), .gfx_rd_data(gfx_rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic reset_dut(input logic cfg);
    @(negedge clk);
    rd = 0; wr = 0; mirror16k_cfg = cfg; rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1; rd = 0;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1; wr = 0;
    @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  task automatic t_reset();
    reset_dut(1'b0);
    check("R1 rdata after reset", rdata, 8'h00);
    check("R1 gfx_sel after reset", {7'd0, gfx_sel}, 8'h00);
  endtask

  task automatic t_ram_mirror();
    logic [7:0] v;
    bus_write(16'h0123, 8'hA5);
    bus_read(16'h0123, v); check("R3 base", v, 8'hA5);
    bus_read(16'h0923, v); check("R3 mirror 1", v, 8'hA5);
    bus_read(16'h1123, v); check("R3 mirror 2", v, 8'hA5);
    bus_read(16'h1923, v); check("R3 mirror 3", v, 8'hA5);
  endtask

  task automatic t_latency();
    logic [7:0] v;
    bus_write(16'h0040, 8'h5A);
    @(negedge clk);
    addr = 16'h0040; rd = 1;
    #1 check("R2 before edge", rdata, 8'hA5);
    @(negedge clk);
    rd = 0;
    check("R2 after edge", rdata, 8'h5A);
    @(negedge clk);
    @(negedge clk);
    check("R2 hold idle", rdata, 8'h5A);
    @(negedge clk);
    addr = 16'h0040; wdata = 8'h77; rd = 1; wr = 1;
    @(negedge clk);
    rd = 0; wr = 0;
    check("R2 both strobes keep rdata", rdata, 8'h5A);
    bus_read(16'h0040, v); check("R2 both strobes wrote", v, 8'h77);
  endtask

  task automatic t_gfx();
    logic [7:0] v;
    @(negedge clk);
    addr = 16'h3FFD; wdata = 8'h12; wr = 1;
    #1 check("R4 sel on write", {7'd0, gfx_sel}, 8'h01);
    check("R4 we on write", {7'd0, gfx_we}, 8'h01);
    check("R4 index 5", {5'd0, gfx_idx}, 8'h05);
    @(negedge clk);
    wr = 0;
    #1 check("R4 sel idle", {7'd0, gfx_sel}, 8'h00);
    @(negedge clk);
    addr = 16'h2002; rd = 1; gfx_rd_data = 8'hC3;
    #1 check("R4 sel on read", {7'd0, gfx_sel}, 8'h01);
    check("R4 we on read", {7'd0, gfx_we}, 8'h00);
    @(negedge clk);
    rd = 0; gfx_rd_data = 8'h00;
    check("R5 gfx read data", rdata, 8'hC3);
    @(negedge clk);
    addr = 16'h0002; rd = 1;
    #1 check("R4 no sel in RAM", {7'd0, gfx_sel}, 8'h00);
    @(negedge clk);
    rd = 0;
    bus_read(16'h0002, v);
  endtask

  task automatic t_io();
    logic [7:0] v;
    bus_write(16'h0017, 8'hEE);
    bus_read(16'h4017, v); check("R6 probe", v, 8'h01);
    bus_read(16'h4016, v); check("R6 other", v, 8'h00);
    bus_write(16'h4017, 8'h9C);
    bus_write(16'h4016, 8'h9C);
    bus_read(16'h4017, v); check("R7 probe after write", v, 8'h01);
    bus_read(16'h4016, v); check("R7 other after write", v, 8'h00);
    bus_read(16'h0017, v); check("R7 RAM untouched", v, 8'hEE);
  endtask

  task automatic t_cart_plain();
    logic [7:0] v;
    bus_write(16'h0100, 8'h11);
    bus_write(16'h4900, 8'h99);
    bus_read(16'h4900, v); check("R8 low cart", v, 8'h99);
    bus_read(16'h0100, v); check("R8 RAM separate", v, 8'h11);
    bus_write(16'h8005, 8'hAA);
    bus_write(16'hC005, 8'h55);
    bus_read(16'h8005, v); check("R8 lower quarter", v, 8'hAA);
    bus_read(16'hC005, v); check("R8 upper quarter", v, 8'h55);
  endtask

  task automatic t_cart_mirror();
    logic [7:0] v;
    reset_dut(1'b1);
    bus_write(16'h8010, 8'h3C);
    bus_read(16'hC010, v); check("R9 upper reads lower", v, 8'h3C);
    bus_write(16'hC020, 8'h7E);
    bus_read(16'h8020, v); check("R9 lower reads upper", v, 8'h7E);
    @(negedge clk);
    mirror16k_cfg = 1'b0;
    bus_write(16'hC030, 8'h4B);
    bus_read(16'h8030, v); check("R9 cfg ignored after reset", v, 8'h4B);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ram_mirror();
    t_latency();
    t_gfx();
    t_io();
    t_cart_plain();
    t_cart_mirror();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule